// File: doc/BRIEF.md
# Pulse-Interval Reader Frame Decoder

This block recovers the bit stream that a reader sends to a tag by pulse-length modulation. The reader briefly removes its field, and each return of the field shows up as a rising edge on a synchronized input. The value of each bit is set by the time between two rising edges, not by the level of the input. A tick input marks every carrier period, and all timing is counted in those units. At a 125 kHz carrier one unit is 8 us. A field-off pulse lasts 4 to 10 units. A zero spans roughly 18 to 22 units and a one roughly 26 to 30.

Each accepted rising edge ends an interval, and the block sorts that interval into one of four classes: noise, a zero, a one, or a gap. A gap is a long pause. It adds no bit, but it is taken as the response time before the frame, less the length of the field-off pulse. Bits are packed MSB first. When the input stays silent for the timeout, the frame is closed. A frame that holds at least one bit is presented together with its bit count, its gap value and an overflow flag. While the tag itself is modulating, a hold-off input stops edges from being accepted.

Top module: `pulse_frame_decoder`

## Requirements
- R1: After reset, frame_valid, frame_bits, frame_count, frame_gap and frame_ovf are all zero.
- R2: An accepted interval of GAP_MIN (36) units or more adds no bit. The frame's gap value becomes the interval minus PULSE_LEN (8).
- R3: An accepted interval from ONE_MIN (25) up to GAP_MIN-1 (35) units appends a 1.
- R4: An accepted interval from ZERO_MIN (15) up to ONE_MIN-1 (24) units appends a 0.
- R5: An accepted interval below ZERO_MIN units adds no bit and leaves the gap value unchanged. The interval count still restarts from that edge.
- R6: The first bit of a frame lands in frame_bits[MAX_BITS-1], and later bits fill successively lower positions. Positions that receive no bit read 0.
- R7: Once EOF_LEN (80) units pass with no accepted edge, the frame closes. frame_valid pulses high for exactly one cycle, in the cycle after the tick that completes the timeout, and only if the frame holds at least one bit. The frame then restarts empty, with gap and overflow cleared.
- R8: The interval counter saturates at 2**CNT_W-1 and does not wrap. The first edge after a long silence therefore reports a gap of 2**CNT_W-1-PULSE_LEN (247 by default).
- R9: Bits that arrive after MAX_BITS bits are already stored are dropped, and frame_ovf is reported with that frame. A frame of exactly MAX_BITS bits does not set frame_ovf.
- R10: A rising edge seen while hold_off is high is ignored. The interval keeps counting from the last accepted edge.
- R11: The interval counter advances only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | High for one cycle per carrier period |
| edge_in | input | 1 | Synchronized field-detector level; rising edges mark pulse ends |
| hold_off | input | 1 | High blocks edge acceptance |
| frame_valid | output | 1 | One-cycle pulse when a non-empty frame closes |
| frame_bits | output | MAX_BITS | Frame data, first bit at the MSB |
| frame_count | output | $clog2(MAX_BITS+1) | Number of bits stored |
| frame_gap | output | CNT_W | Gap before the frame minus PULSE_LEN |
| frame_ovf | output | 1 | Bits were dropped beyond MAX_BITS |

## Verification
The bench builds the block with MAX_BITS set to 16 and the default timing and counter width. This brings overflow within reach after 17 bits, and counter saturation at 255 within a few hundred cycles. The tick is held high for most of the run, so each interval equals a count of clock cycles. This lets the bench sweep every interval from 2 to 79 units through all four classes and across both sides of every threshold. Gated ticks, edges made while hold-off is high, full and over-full frames, and frames with no bits cover the remaining rules.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        CLS_NOISE = 2'd0,
        CLS_ZERO  = 2'd1,
        CLS_ONE   = 2'd2,
        CLS_GAP   = 2'd3
    } pulse_cls_e;
endpackage

// File: rtl/pfd_interval.sv
module pfd_interval #(
    parameter int CNT_W   = 8,
    parameter int EOF_LEN = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_in,
    input  logic             tick,
    input  logic             hold_off,
    output logic             rise,
    output logic [CNT_W-1:0] interval,
    output logic             close
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] EOF_M1  = CNT_W'(EOF_LEN - 1);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } ivl_state_t;

    ivl_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = edge_in;
        rise     = edge_in && !s_q.prev && !hold_off;
        close    = 1'b0;
        if (rise) begin
            s_d.cnt = tick ? CNT_W'(1) : '0;
        end else if (tick) begin
            if (s_q.cnt != CNT_MAX) begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
            close = (s_q.cnt == EOF_M1);
        end
    end

    assign interval = s_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !rise) |=> (s_q.cnt == CNT_MAX));

    a_r11_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !rise) |=> $stable(s_q.cnt));

    a_r10_hold_keeps_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_off && tick && s_q.cnt != CNT_MAX) |=> (s_q.cnt == $past(s_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/pfd_classify.sv
module pfd_classify
    import pfd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int ZERO_MIN  = 15,
    parameter int ONE_MIN   = 25,
    parameter int GAP_MIN   = 36,
    parameter int PULSE_LEN = 8
) (
    input  logic [CNT_W-1:0] interval,
    output pulse_cls_e       cls,
    output logic [CNT_W-1:0] gap
);
    localparam logic [CNT_W-1:0] TH_ZERO = CNT_W'(ZERO_MIN);
    localparam logic [CNT_W-1:0] TH_ONE  = CNT_W'(ONE_MIN);
    localparam logic [CNT_W-1:0] TH_GAP  = CNT_W'(GAP_MIN);
    localparam logic [CNT_W-1:0] PL      = CNT_W'(PULSE_LEN);

    always_comb begin
        if (interval >= TH_GAP)       cls = CLS_GAP;
        else if (interval >= TH_ONE)  cls = CLS_ONE;
        else if (interval >= TH_ZERO) cls = CLS_ZERO;
        else                          cls = CLS_NOISE;
        gap = interval - PL;
    end
endmodule

// File: rtl/pfd_assemble.sv
module pfd_assemble
    import pfd_pkg::*;
#(
    parameter int MAX_BITS = 160,
    parameter int CNT_W    = 8,
    localparam int BC_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  pulse_cls_e          cls,
    input  logic [CNT_W-1:0]    gap,
    input  logic                close,
    output logic                frame_valid,
    output logic [MAX_BITS-1:0] frame_bits,
    output logic [BC_W-1:0]     frame_count,
    output logic [CNT_W-1:0]    frame_gap,
    output logic                frame_ovf
);
    localparam logic [BC_W-1:0] FULL = BC_W'(MAX_BITS);

    typedef struct packed {
        logic [MAX_BITS-1:0] bits;
        logic [BC_W-1:0]     n;
        logic [CNT_W-1:0]    gap;
        logic                ovf;
        logic                o_valid;
        logic [MAX_BITS-1:0] o_bits;
        logic [BC_W-1:0]     o_n;
        logic [CNT_W-1:0]    o_gap;
        logic                o_ovf;
    } asm_state_t;

    asm_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.o_valid = 1'b0;
        if (close) begin
            if (s_q.n != '0) begin
                s_d.o_valid = 1'b1;
                s_d.o_bits  = s_q.bits;
                s_d.o_n     = s_q.n;
                s_d.o_gap   = s_q.gap;
                s_d.o_ovf   = s_q.ovf;
            end
            s_d.bits = '0;
            s_d.n    = '0;
            s_d.gap  = '0;
            s_d.ovf  = 1'b0;
        end else if (rise) begin
            case (cls)
                CLS_GAP: s_d.gap = gap;
                CLS_ZERO, CLS_ONE: begin
                    if (s_q.n == FULL) begin
                        s_d.ovf = 1'b1;
                    end else begin
                        for (int i = 0; i < MAX_BITS; i++) begin
                            if (i == MAX_BITS - 1 - int'(s_q.n)) s_d.bits[i] = (cls == CLS_ONE);
                        end
                        s_d.n = s_q.n + BC_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame_valid = s_q.o_valid;
    assign frame_bits  = s_q.o_bits;
    assign frame_count = s_q.o_n;
    assign frame_gap   = s_q.o_gap;
    assign frame_ovf   = s_q.o_ovf;

    a_r7_emit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_count != '0));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    a_r9_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_count <= FULL);

    a_r9_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf |-> (frame_count == FULL));
endmodule

// File: rtl/pulse_frame_decoder.sv
module pulse_frame_decoder
    import pfd_pkg::*;
#(
    parameter int MAX_BITS  = 160,
    parameter int CNT_W     = 8,
    parameter int ZERO_MIN  = 15,
    parameter int ONE_MIN   = 25,
    parameter int GAP_MIN   = 36,
    parameter int PULSE_LEN = 8,
    parameter int EOF_LEN   = 80,
    localparam int BC_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                edge_in,
    input  logic                hold_off,
    output logic                frame_valid,
    output logic [MAX_BITS-1:0] frame_bits,
    output logic [BC_W-1:0]     frame_count,
    output logic [CNT_W-1:0]    frame_gap,
    output logic                frame_ovf
);
    logic             rise;
    logic             close;
    logic [CNT_W-1:0] interval;
    logic [CNT_W-1:0] gap;
    pulse_cls_e       cls;

    pfd_interval #(.CNT_W(CNT_W), .EOF_LEN(EOF_LEN)) u_interval (
        .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .tick(tick), .hold_off(hold_off),
        .rise(rise), .interval(interval), .close(close)
    );

    pfd_classify #(.CNT_W(CNT_W), .ZERO_MIN(ZERO_MIN), .ONE_MIN(ONE_MIN),
                   .GAP_MIN(GAP_MIN), .PULSE_LEN(PULSE_LEN)) u_classify (
        .interval(interval), .cls(cls), .gap(gap)
    );

    pfd_assemble #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_assemble (
        .clk(clk), .rst_n(rst_n), .rise(rise), .cls(cls), .gap(gap), .close(close),
        .frame_valid(frame_valid), .frame_bits(frame_bits), .frame_count(frame_count),
        .frame_gap(frame_gap), .frame_ovf(frame_ovf)
    );
endmodule

// File: tb/pulse_frame_decoder_bench.sv
module pulse_frame_decoder_bench;
    localparam int MB = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic          edge_in;
    logic          hold_off;
    logic          frame_valid;
    logic [MB-1:0] frame_bits;
    logic [4:0]    frame_count;
    logic [7:0]    frame_gap;
    logic          frame_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [MB-1:0] exp_bits;
    int            exp_n;
    logic          exp_ovf;
    int            exp_gap;
    int            since_acc;

    always #4 clk = ~clk;

    pulse_frame_decoder #(.MAX_BITS(MB)) u_pulse_frame_decoder (
        .clk(clk), .rst_n(rst_n), .tick(tick), .edge_in(edge_in), .hold_off(hold_off),
        .frame_valid(frame_valid), .frame_bits(frame_bits), .frame_count(frame_count),
        .frame_gap(frame_gap), .frame_ovf(frame_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic b);
        if (exp_n < MB) begin
            exp_bits[MB-1-exp_n] = b;
            exp_n++;
        end else begin
            exp_ovf = 1'b1;
        end
    endtask

    task automatic begin_frame();
        edge_in = 1'b0;
        hold_off = 1'b0;
        tick = 1'b1;
        repeat (300) @(negedge clk);
        edge_in = 1'b1;
        exp_bits = '0;
        exp_n = 0;
        exp_ovf = 1'b0;
        exp_gap = 247;
        since_acc = 0;
    endtask

    // next rising edge n cycles after the previous one; tick low for the first slow cycles
    task automatic step(input int n, input bit hold, input int slow);
        int iv;
        @(negedge clk);
        edge_in = 1'b0;
        hold_off = 1'b0;
        if (slow > 0) tick = 1'b0;
        for (int i = 2; i <= n; i++) begin
            @(negedge clk);
            if (i == slow + 1) tick = 1'b1;
        end
        edge_in = 1'b1;
        hold_off = hold;
        iv = since_acc + ((slow > 0) ? n - slow : n);
        if (hold) begin
            since_acc = iv;
        end else begin
            since_acc = 0;
            if (iv >= 36)      exp_gap = iv - 8;
            else if (iv >= 25) push(1'b1);
            else if (iv >= 15) push(1'b0);
        end
    endtask

    task automatic end_frame(input string bit_req, input string gap_req);
        int seen = 0;
        logic [MB-1:0] c_bits = '0;
        int c_n = 0;
        int c_gap = 0;
        logic c_ovf = 1'b0;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            edge_in = 1'b0;
            hold_off = 1'b0;
            if (frame_valid && seen == 0) begin
                seen = k;
                c_bits = frame_bits;
                c_n = int'(frame_count);
                c_gap = int'(frame_gap);
                c_ovf = frame_ovf;
            end
        end
        if (exp_n > 0) begin
            chk("R7 close delay", seen, 80);
            chk(bit_req, c_bits, exp_bits);
            chk("R6 count", c_n, exp_n);
            chk(gap_req, c_gap, exp_gap);
            chk("R9 ovf", c_ovf, exp_ovf);
        end else begin
            chk("R7 empty frame not emitted", seen, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        edge_in = 1'b0;
        tick = 1'b1;
        hold_off = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", frame_valid, 0);
        chk("R1 bits", frame_bits, 0);
        chk("R1 count", frame_count, 0);
        chk("R1 gap", frame_gap, 0);
        chk("R1 ovf", frame_ovf, 0);

        // sweep of the first interval across every class boundary
        for (int n = 2; n <= 79; n++) begin
            begin_frame();
            step(n, 1'b0, 0);
            step(20, 1'b0, 0);
            if (n < 15)      end_frame("R5 noise", "R8 gap");
            else if (n < 25) end_frame("R4 zero", "R8 gap");
            else if (n < 36) end_frame("R3 one", "R8 gap");
            else             end_frame("R4 after gap", "R2 gap");
        end

        // full frame, MSB-first pattern with varied spacing
        begin
            logic [15:0] pat = 16'hB5C3;
            begin_frame();
            for (int i = 0; i < 16; i++) begin
                if (pat[15-i]) step(25 + (i % 4) * 3 + ((i % 4) == 3 ? 1 : 0), 1'b0, 0);
                else           step(15 + (i % 4) * 3, 1'b0, 0);
            end
            end_frame("R6 pattern full", "R8 gap");
        end

        // overflow: 18 bits into 16 places
        begin_frame();
        for (int i = 0; i < 18; i++) step((i % 2 == 0) ? 28 : 20, 1'b0, 0);
        end_frame("R9 overflow bits", "R8 gap");

        // short frame, unused positions stay zero
        begin_frame();
        step(30, 1'b0, 0);
        step(30, 1'b0, 0);
        step(18, 1'b0, 0);
        end_frame("R6 short frame", "R8 gap");

        // hold-off blocks an edge; interval keeps counting
        begin_frame();
        step(20, 1'b0, 0);
        step(10, 1'b1, 0);
        step(18, 1'b0, 0);
        end_frame("R10 held edge", "R8 gap");

        // tick gating: 40 cycles with 20 ticks reads as a zero
        begin_frame();
        step(20, 1'b0, 0);
        step(40, 1'b0, 20);
        end_frame("R11 gated tick", "R8 gap");

        // frames with no bits
        begin_frame();
        step(5, 1'b0, 0);
        end_frame("R5 noise only", "R8 gap");
        begin_frame();
        step(50, 1'b0, 0);
        end_frame("R2 gap only", "R2 gap");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule